// File: doc/BRIEF.md
# Receive Descriptor Status Write-Back Engine

This block closes out received frames by updating a ring of 16-byte receive descriptors held in an internal RAM. The host prepares each descriptor by writing its control word with the buffer capacity in the low bits and the ownership flag set. When a completed frame arrives with its length and status flags, the engine reads the control word of the descriptor at the current ring position. If the host has handed that descriptor over, the engine writes the result back into it. The result holds the length, the error and address-match flags, and single-segment markers. Ownership returns to the host and the ring position moves on.

If the descriptor is still held by the host, the frame is dropped and counted, and the ring position stays where it is. The engine does not move payload data. Address filtering and checksum work happen upstream and arrive here only as flags. A sticky interrupt status word tells the host what happened. Software clears its bits by writing ones, and it clears the missed-frame counter with a single pulse.

The host reaches every word of every descriptor through a simple word-addressed port. Reads on that port have one cycle of latency. The engine takes one frame at a time and lowers its ready output while a frame is being processed.

Top module: `rxwb_engine`

## Requirements
- R1: After reset, `frm_ready` is 1, `irq_status` is 0, `miss_count` is 0, and the first frame is handled at descriptor 0.
- R2: For a frame offered to a descriptor whose bit 31 (owned by engine) is 1, the engine writes the control word (word 0 of the descriptor) as follows. Bits 13:0 hold the offered length, which includes the 4-byte CRC. Bit 31 is cleared. Bit 29 (first segment) and bit 28 (last segment) are set. `irq_status` bit 0 (receive OK) is set when the frame has no error.
- R3: The address flags are copied into the written word: broadcast to bit 25, physical match to bit 26 and multicast to bit 27.
- R4: The error flags are copied as CRC error to bit 19, runt to bit 20, watchdog to bit 22 and FIFO overflow to bit 23. Bit 21 (error summary) is set when any of them is set. Such a frame sets `irq_status` bit 1 (receive error) and not bit 0.
- R5: The buffer capacity is bits 13:0 of the armed word. A frame longer than that capacity is written with its length clamped to the capacity, and with bit 24 (buffer overflow) and bit 21 set. It sets `irq_status` bit 1. A frame exactly equal to the capacity is not an overflow.
- R6: A frame offered to a descriptor whose bit 31 is 0 leaves that descriptor unchanged. It sets `irq_status` bit 4 (no descriptor), adds 1 to `miss_count`, and leaves the ring position where it was.
- R7: A `miss_clr` pulse sets `miss_count` to 0 in the next cycle.
- R8: The engine keeps bit 30 (end of ring) of the armed word in the word it writes back. After a descriptor with bit 30 set, or after descriptor NDESC-1, the next frame goes to descriptor 0. Otherwise it goes to the next index.
- R9: Bits of `irq_status` stay set until the host writes a 1 to the same bit of `isr_clr`. Bits whose `isr_clr` bit is 0 are not affected.
- R10: `frm_valid` is taken only while `frm_ready` is 1. A frame offered while `frm_ready` is 0 has no effect on descriptors, status or counter.
- R11: A host write to a word address updates that word. A host read returns the word on `host_rdata` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Completed frame offered |
| frm_len | input | 14 | Frame length in bytes, CRC included |
| frm_crc_err | input | 1 | CRC error flag |
| frm_runt | input | 1 | Runt frame flag |
| frm_wdog | input | 1 | Receive watchdog expired flag |
| frm_fifo_ovf | input | 1 | Receive FIFO overflow flag |
| frm_bcast | input | 1 | Broadcast address flag |
| frm_phys | input | 1 | Station address match flag |
| frm_mcast | input | 1 | Multicast address flag |
| frm_ready | output | 1 | Engine idle and able to take a frame |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | $clog2(NDESC)+2 (6) | Host word address, descriptor index times 4 plus word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after address |
| isr_clr | input | 16 | Write-one-to-clear mask for status bits |
| miss_clr | input | 1 | Clear the missed-frame counter |
| irq_status | output | 16 | Sticky status: bit 0 OK, bit 1 error, bit 4 no descriptor |
| miss_count | output | CNT_W (32) | Frames dropped for lack of a descriptor |

## Verification
The bench aims at several edge cases, each of which a plausible bug would break:
- A frame whose length equals the buffer capacity. An off-by-one comparison would flag it as overflow.
- A frame offered to a descriptor the host still holds. A careless engine would still advance the ring, or write the descriptor anyway, leaving the host's ring out of step.
- A descriptor with the end-of-ring flag. Losing that flag in the written word, or not wrapping after it, sends later frames into memory the host never armed.
- A second frame offered while the engine is busy. A design that took it would overwrite the following descriptor.
- A partial status clear. A clear that is too broad would drop events the host has not yet seen.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    localparam int LEN_W   = 14;
    localparam int WORD_W  = 32;
    localparam int ISR_W   = 16;

    // control word bit positions (decoded by host software)
    localparam int CW_OWN   = 31;
    localparam int CW_EOR   = 30;
    localparam int CW_FS    = 29;
    localparam int CW_LS    = 28;
    localparam int CW_MCAST = 27;
    localparam int CW_PHYS  = 26;
    localparam int CW_BCAST = 25;
    localparam int CW_BOVF  = 24;
    localparam int CW_FOVF  = 23;
    localparam int CW_WDOG  = 22;
    localparam int CW_ESUM  = 21;
    localparam int CW_RUNT  = 20;
    localparam int CW_CRC   = 19;

    // interrupt status bit positions
    localparam int IRQ_OK     = 0;
    localparam int IRQ_ERR    = 1;
    localparam int IRQ_NODESC = 4;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             crc_err;
        logic             runt;
        logic             wdog;
        logic             fifo_ovf;
        logic             bcast;
        logic             phys;
        logic             mcast;
    } rx_frame_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WRITE = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              err;
    } wb_result_t;

    function automatic wb_result_t build_wb(input logic [WORD_W-1:0] armed,
                                            input rx_frame_t f);
        wb_result_t       r;
        logic [LEN_W-1:0] cap;
        logic             ovf;
        logic             any_err;
        cap     = armed[LEN_W-1:0];
        ovf     = (f.len > cap);
        any_err = f.crc_err | f.runt | f.wdog | f.fifo_ovf | ovf;
        r.word  = '0;
        r.word[LEN_W-1:0] = ovf ? cap : f.len;
        r.word[CW_CRC]    = f.crc_err;
        r.word[CW_RUNT]   = f.runt;
        r.word[CW_ESUM]   = any_err;
        r.word[CW_WDOG]   = f.wdog;
        r.word[CW_FOVF]   = f.fifo_ovf;
        r.word[CW_BOVF]   = ovf;
        r.word[CW_BCAST]  = f.bcast;
        r.word[CW_PHYS]   = f.phys;
        r.word[CW_MCAST]  = f.mcast;
        r.word[CW_LS]     = 1'b1;
        r.word[CW_FS]     = 1'b1;
        r.word[CW_EOR]    = armed[CW_EOR];
        r.word[CW_OWN]    = 1'b0;
        r.err  = any_err;
        return r;
    endfunction

endpackage

// File: rtl/rxwb_desc_ram.sv
module rxwb_desc_ram
    import rxwb_pkg::*;
#(
    parameter int NDESC = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_we,
    input  logic [$clog2(NDESC)+1:0] host_addr,
    input  logic [WORD_W-1:0]       host_wdata,
    output logic [WORD_W-1:0]       host_rdata,
    input  logic [$clog2(NDESC)-1:0] eng_idx,
    output logic [WORD_W-1:0]       eng_ctl,
    input  logic                    eng_we,
    input  logic [WORD_W-1:0]       eng_wdata
);
    localparam int IW    = $clog2(NDESC);
    localparam int AW    = IW + 2;
    localparam int WORDS = NDESC * 4;

    logic [WORD_W-1:0] mem [WORDS];
    logic [AW-1:0]     eng_addr;

    assign eng_addr = {eng_idx, 2'b00};
    assign eng_ctl  = mem[eng_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            host_rdata <= '0;
        end else begin
            host_rdata <= mem[host_addr];
            if (host_we && !(eng_we && host_addr == eng_addr))
                mem[host_addr] <= host_wdata;
            if (eng_we)
                mem[eng_addr] <= eng_wdata;
        end
    end
endmodule

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
    parameter int NDESC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     advance,
    input  logic                     wrap,
    output logic [$clog2(NDESC)-1:0] idx
);
    localparam int IW = $clog2(NDESC);
    localparam logic [IW-1:0] LAST = IW'(NDESC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (advance) begin
            if (wrap || idx == LAST) idx <= '0;
            else                     idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/rxwb_status.sv
module rxwb_status
    import rxwb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_ok,
    input  logic              set_err,
    input  logic              set_nodesc,
    input  logic [ISR_W-1:0]  isr_clr,
    input  logic              miss_clr,
    output logic [ISR_W-1:0]  irq_status,
    output logic [CNT_W-1:0]  miss_count
);
    logic [ISR_W-1:0] set_mask;

    always_comb begin
        set_mask             = '0;
        set_mask[IRQ_OK]     = set_ok;
        set_mask[IRQ_ERR]    = set_err;
        set_mask[IRQ_NODESC] = set_nodesc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_status <= '0;
            miss_count <= '0;
        end else begin
            irq_status <= (irq_status & ~isr_clr) | set_mask;
            if (miss_clr)        miss_count <= '0;
            else if (set_nodesc) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl
    import rxwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  rx_frame_t         frm_in,
    output logic              frm_ready,
    input  logic [WORD_W-1:0] ctl_word,
    output logic              wb_we,
    output logic [WORD_W-1:0] wb_word,
    output logic              advance,
    output logic              wrap,
    output logic              set_ok,
    output logic              set_err,
    output logic              set_nodesc
);
    eng_state_t        state;
    rx_frame_t         frm_q;
    logic [WORD_W-1:0] ctl_q;
    wb_result_t        res;
    logic              owned;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            frm_q <= '0;
            ctl_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (frm_valid) begin
                    frm_q <= frm_in;
                    state <= S_FETCH;
                end
                S_FETCH: begin
                    ctl_q <= ctl_word;
                    state <= S_WRITE;
                end
                S_WRITE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        res        = build_wb(ctl_q, frm_q);
        owned      = ctl_q[CW_OWN];
        frm_ready  = (state == S_IDLE);
        wb_word    = res.word;
        wb_we      = 1'b0;
        advance    = 1'b0;
        wrap       = 1'b0;
        set_ok     = 1'b0;
        set_err    = 1'b0;
        set_nodesc = 1'b0;
        if (state == S_WRITE) begin
            if (owned) begin
                wb_we   = 1'b1;
                advance = 1'b1;
                wrap    = ctl_q[CW_EOR];
                set_ok  = !res.err;
                set_err = res.err;
            end else begin
                set_nodesc = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
    import rxwb_pkg::*;
#(
    parameter int NDESC = 16,
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frm_valid,
    input  logic [13:0]              frm_len,
    input  logic                     frm_crc_err,
    input  logic                     frm_runt,
    input  logic                     frm_wdog,
    input  logic                     frm_fifo_ovf,
    input  logic                     frm_bcast,
    input  logic                     frm_phys,
    input  logic                     frm_mcast,
    output logic                     frm_ready,
    input  logic                     host_we,
    input  logic [$clog2(NDESC)+1:0] host_addr,
    input  logic [31:0]              host_wdata,
    output logic [31:0]              host_rdata,
    input  logic [15:0]              isr_clr,
    input  logic                     miss_clr,
    output logic [15:0]              irq_status,
    output logic [CNT_W-1:0]         miss_count
);
    localparam int IW = $clog2(NDESC);

    rx_frame_t         frm_in;
    logic [IW-1:0]     ring_idx;
    logic [WORD_W-1:0] ctl_word;
    logic [WORD_W-1:0] wb_word;
    logic              wb_we, advance, wrap;
    logic              set_ok, set_err, set_nodesc;

    assign frm_in = '{len:      frm_len,
                      crc_err:  frm_crc_err,
                      runt:     frm_runt,
                      wdog:     frm_wdog,
                      fifo_ovf: frm_fifo_ovf,
                      bcast:    frm_bcast,
                      phys:     frm_phys,
                      mcast:    frm_mcast};

    rxwb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frm_valid  (frm_valid),
        .frm_in     (frm_in),
        .frm_ready  (frm_ready),
        .ctl_word   (ctl_word),
        .wb_we      (wb_we),
        .wb_word    (wb_word),
        .advance    (advance),
        .wrap       (wrap),
        .set_ok     (set_ok),
        .set_err    (set_err),
        .set_nodesc (set_nodesc)
    );

    rxwb_desc_ram #(.NDESC(NDESC)) u_ram (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_idx    (ring_idx),
        .eng_ctl    (ctl_word),
        .eng_we     (wb_we),
        .eng_wdata  (wb_word)
    );

    rxwb_ring_ptr #(.NDESC(NDESC)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .wrap    (wrap),
        .idx     (ring_idx)
    );

    rxwb_status #(.CNT_W(CNT_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .set_ok     (set_ok),
        .set_err    (set_err),
        .set_nodesc (set_nodesc),
        .isr_clr    (isr_clr),
        .miss_clr   (miss_clr),
        .irq_status (irq_status),
        .miss_count (miss_count)
    );
endmodule

// File: rtl/rxwb_checker.sv
module rxwb_checker #(
    parameter int NDESC = 16,
    parameter int CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frm_valid,
    input logic                     frm_ready,
    input logic [15:0]              isr_clr,
    input logic                     miss_clr,
    input logic [15:0]              irq_status,
    input logic [CNT_W-1:0]         miss_count,
    input logic [$clog2(NDESC)-1:0] ring_idx
);
    localparam int IW = $clog2(NDESC);

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(miss_clr) |-> (miss_count == $past(miss_count) ||
                              miss_count == $past(miss_count) + 1'b1)); // R6

    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        miss_clr |=> (miss_count == '0)); // R7

    AST_ISR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (isr_clr == '0) |=> ((irq_status & $past(irq_status)) == $past(irq_status))); // R9

    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !($rose(irq_status[0]) && $rose(irq_status[1]))); // R4

    AST_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $fell(frm_ready) |-> $past(frm_valid)); // R10

    AST_RING_STEP: assert property (@(posedge clk) disable iff (rst)
        (ring_idx != $past(ring_idx)) |->
            (ring_idx == '0 || ring_idx == IW'($past(ring_idx) + 1'b1))); // R8
endmodule

bind rxwb_engine rxwb_checker #(.NDESC(NDESC), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .isr_clr    (isr_clr),
    .miss_clr   (miss_clr),
    .irq_status (irq_status),
    .miss_count (miss_count),
    .ring_idx   (ring_idx)
);

// File: tb/tb_rxwb_engine.sv
module tb_rxwb_engine;
    localparam int N  = 16;
    localparam int AW = $clog2(N) + 2;

    logic        clk = 0;
    logic        rst;
    logic        frm_valid;
    logic [13:0] frm_len;
    logic        frm_crc_err, frm_runt, frm_wdog, frm_fifo_ovf;
    logic        frm_bcast, frm_phys, frm_mcast;
    logic        frm_ready;
    logic        host_we;
    logic [AW-1:0] host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic [15:0] isr_clr;
    logic        miss_clr;
    logic [15:0] irq_status;
    logic [31:0] miss_count;

    always #2 clk = ~clk;

    rxwb_engine #(.NDESC(N), .CNT_W(32)) dut (.*);

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [31:0] shadow [N];
    int          m_idx = 0;
    logic [15:0] m_isr = 0;
    logic [31:0] m_miss = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // flags: {mcast, phys, bcast, fifo_ovf, wdog, runt, crc}
    function automatic logic [32:0] exp_wb(input logic [31:0] armed, input int len, input logic [6:0] f);
        logic [31:0] w;
        int cap;
        bit ov, err;
        cap = int'(armed[13:0]);
        ov  = len > cap;
        err = (|f[3:0]) || ov;
        w = 0;
        w[13:0] = ov ? cap[13:0] : len[13:0];
        w[19] = f[0]; w[20] = f[1]; w[22] = f[2]; w[23] = f[3];
        w[25] = f[4]; w[26] = f[5]; w[27] = f[6];
        w[24] = ov; w[21] = err; w[29] = 1; w[28] = 1; w[30] = armed[30];
        return {err, w};
    endfunction

    task automatic host_wr(input int a, input logic [31:0] d);
        @(negedge clk); host_we = 1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk); host_we = 0;
    endtask

    task automatic host_rd(input int a, output logic [31:0] d);
        @(negedge clk); host_addr = AW'(a);
        @(negedge clk); d = host_rdata;
    endtask

    task automatic arm(input int i, input int cap, input bit own, input bit eor);
        logic [31:0] w;
        w = 0; w[31] = own; w[30] = eor; w[13:0] = cap[13:0];
        host_wr(i * 4, w);
        shadow[i] = w;
    endtask

    task automatic send(input int len, input logic [6:0] f, input bit dup);
        @(negedge clk);
        frm_valid = 1; frm_len = len[13:0];
        {frm_mcast, frm_phys, frm_bcast, frm_fifo_ovf, frm_wdog, frm_runt, frm_crc_err} = f;
        @(negedge clk);
        if (dup) begin
            frm_len = 14'd33; frm_crc_err = 1;
            @(negedge clk);
        end
        frm_valid = 0;
        while (!frm_ready) @(negedge clk);
    endtask

    task automatic do_frame(input int len, input logic [6:0] f, input bit dup, input string tag);
        int i;
        logic [31:0] armed, rd;
        logic [32:0] e;
        i = m_idx;
        armed = shadow[i];
        send(len, f, dup);
        if (armed[31]) begin
            e = exp_wb(armed, len, f);
            shadow[i] = e[31:0];
            m_idx = armed[30] ? 0 : (i + 1) % N;
            m_isr |= e[32] ? 16'h0002 : 16'h0001;
        end else begin
            m_miss++;
            m_isr |= 16'h0010;
        end
        host_rd(i * 4, rd);
        chk(rd == shadow[i], $sformatf("%s desc%0d word", tag, i), rd, shadow[i]);
        chk(irq_status == m_isr, $sformatf("%s irq_status", tag), irq_status, m_isr);
        chk(miss_count == m_miss, $sformatf("%s miss_count", tag), miss_count, m_miss);
    endtask

    task automatic clr_isr(input logic [15:0] m);
        @(negedge clk); isr_clr = m;
        @(negedge clk); isr_clr = 0;
        m_isr &= ~m;
        chk(irq_status == m_isr, "R9 partial/complete clear", irq_status, m_isr);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd, seed;
        int nxt;
        seed = $urandom(32'h5EED);
        rst = 1; frm_valid = 0; frm_len = 0;
        {frm_mcast, frm_phys, frm_bcast, frm_fifo_ovf, frm_wdog, frm_runt, frm_crc_err} = 0;
        host_we = 0; host_addr = 0; host_wdata = 0; isr_clr = 0; miss_clr = 0;
        for (int i = 0; i < N; i++) shadow[i] = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(frm_ready == 1, "R1 frm_ready", frm_ready, 1);
        chk(irq_status == 0, "R1 irq_status", irq_status, 0);
        chk(miss_count == 0, "R1 miss_count", miss_count, 0);
        // R11 host port
        host_wr(1, 32'hA5A5_1234);
        host_wr(6, 32'h0BAD_F00D);
        host_rd(1, rd);
        chk(rd == 32'hA5A5_1234, "R11 readback word1", rd, 32'hA5A5_1234);
        host_rd(6, rd);
        chk(rd == 32'h0BAD_F00D, "R11 readback word6", rd, 32'h0BAD_F00D);
        // R2 good frame at descriptor 0 (also R1: first frame at index 0)
        arm(0, 1536, 1, 0);
        do_frame(64, 7'b0100000, 0, "R2 R1");
        // R3 address flags
        arm(1, 1536, 1, 0);
        do_frame(1518, 7'b1010000, 0, "R3");
        // R4 errors
        clr_isr(16'hFFFF);
        arm(2, 1536, 1, 0);
        do_frame(100, 7'b0001001, 0, "R4");
        chk(irq_status[1:0] == 2'b10, "R4 err not ok", irq_status[1:0], 2'b10);
        arm(3, 1536, 1, 0);
        do_frame(90, 7'b0000110, 0, "R4 runt/wdog");
        // R5 overflow and exact fit
        clr_isr(16'hFFFF);
        arm(4, 200, 1, 0);
        do_frame(300, 7'b0000000, 0, "R5 overflow");
        clr_isr(16'hFFFF);
        arm(5, 200, 1, 0);
        do_frame(200, 7'b0000000, 0, "R5 exact fit");
        chk(irq_status == 16'h0001, "R5 exact fit ok", irq_status, 16'h0001);
        // R6 not owned
        arm(6, 1000, 0, 0);
        do_frame(80, 7'b0000000, 0, "R6 drop");
        arm(6, 1000, 1, 0);
        do_frame(81, 7'b0000000, 0, "R6 no advance");
        // R7 miss clear
        @(negedge clk); miss_clr = 1;
        @(negedge clk); miss_clr = 0;
        m_miss = 0;
        chk(miss_count == 0, "R7 miss cleared", miss_count, 0);
        // R9 partial clear
        clr_isr(16'h0010);
        // R8 end-of-ring
        arm(7, 1536, 1, 1);
        do_frame(70, 7'b0000000, 0, "R8 eor kept");
        chk(m_idx == 0, "R8 model wrap", m_idx, 0);
        arm(0, 1536, 1, 0);
        do_frame(72, 7'b0000000, 0, "R8 wrapped to 0");
        // R10 frame while busy ignored
        nxt = (m_idx + 1) % N;
        arm(m_idx, 1536, 1, 0);
        arm(nxt, 1536, 1, 0);
        do_frame(128, 7'b0000000, 1, "R10 first");
        host_rd(nxt * 4, rd);
        chk(rd == shadow[nxt], "R10 next desc untouched", rd, shadow[nxt]);
        // random mix, covers wrap at last index (R8) and general (R2)
        for (int k = 0; k < 70; k++) begin
            logic [6:0] f;
            f = 0;
            for (int b = 0; b < 7; b++) f[b] = ($urandom % 8) == 0;
            arm(m_idx, 64 + ($urandom % 1500), ($urandom % 5) != 0, ($urandom % 10) == 0);
            do_frame(20 + ($urandom % 1700), f, 0, "R2 R8 random");
            if (($urandom % 6) == 0) clr_isr(16'($urandom));
        end
        done = 1;
        finish_run();
    end
endmodule